// File: doc/BRIEF.md
# Border Double-Excitation Resolver for Light-Grid Sense Lines

This block sits between one axis of thresholded light-sensor lines and the coder that turns the excited line into a binary position. A light spot placed on the border between two neighbouring squares can excite both neighbouring lines at once, because their sensitive areas overlap. The block decides what reaches the coder when that happens. One instance serves the row lines and a second, identical instance serves the column lines.

A policy input selects between two behaviours. In warning policy, any pattern with more than one excited line lights a warning lamp output and raises a strobe-inhibit output, so that no serial code is sent. In lowest-code policy, the lowest-indexed excited line is passed on alone, as if it were the only one lit, and no warning is given. In both policies a single excited line passes through unchanged. All outputs are combinational functions of the current inputs.

Line index 0 carries the smallest position code, and the code rises with the index.

Top module: `amb_resolver`

## Requirements
- R1: With no line excited, `clean_lines` is all zero and both `warn_lamp` and `strobe_block` are 0, in either policy.
- R2: With exactly one line excited, `clean_lines` equals `sense_lines`, and `warn_lamp` and `strobe_block` are 0, in either policy.
- R3: In warning policy (`policy_sel` = 0), two excited neighbouring lines (index i and i+1) drive `warn_lamp` to 1.
- R4: In warning policy, any pattern of two or more excited lines drives `strobe_block` to 1 and `clean_lines` to all zero.
- R5: In warning policy, two excited lines that are not neighbours also drive both `warn_lamp` and `strobe_block` to 1.
- R6: In lowest-code policy (`policy_sel` = 1), two excited lines yield `clean_lines` with only the lower-index line set, with `warn_lamp` and `strobe_block` at 0.
- R7: In lowest-code policy, three or more excited lines yield `clean_lines` holding only the lowest-index excited line.
- R8: The outputs follow the inputs with no clock: a change on `sense_lines` or `policy_sel` is visible on the outputs without waiting for any edge.
- R9: `clean_lines` never has more than one bit set and never has a bit set that is clear in `sense_lines`; `warn_lamp` and `strobe_block` are always equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sense_lines | input | LINES | Thresholded sensor lines of one axis, bit 0 = smallest code |
| policy_sel | input | 1 | 0 = warning policy, 1 = lowest-code policy |
| clean_lines | output | LINES | At most one-hot line vector for the position coder |
| warn_lamp | output | 1 | Drives the user warning lamp on multi-line excitation |
| strobe_block | output | 1 | Holds the serial output strobe inactive |

## Verification
The hardest situations to reach are the multi-line patterns in which the lowest excited line sits at the top end of the vector or where three or more lines, not all neighbours, are lit, since uniform random vectors of this width almost never produce exactly one or exactly two neighbouring bits. The stimulus therefore draws a pattern class first (empty, single line, neighbouring pair, spread pair, dense random) and only then the positions, and adds directed vectors for the pair at the top two indices, the pair at the bottom two, and the all-lines-lit case under both policies. Each vector is also replayed with the policy flipped so that the same pattern is seen under both behaviours.

// File: rtl/amb_pkg.sv
package amb_pkg;
    typedef enum logic {
        POL_WARN   = 1'b0,
        POL_LOWEST = 1'b1
    } policy_e;
endpackage

// File: rtl/amb_lowest_isolate.sv
module amb_lowest_isolate #(
    parameter int LINES = 8
) (
    input  logic [LINES-1:0] raw_lines,
    output logic [LINES-1:0] first_line,
    output logic             multi_hot
);
    // seen_below[i] is set when any line with index below i is excited
    logic [LINES:0]   seen_below;
    logic [LINES-1:0] dup_line;

    assign seen_below[0] = 1'b0;

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_chain
            assign seen_below[i+1] = seen_below[i] | raw_lines[i];
            assign first_line[i]   = raw_lines[i] & ~seen_below[i];
            assign dup_line[i]     = raw_lines[i] &  seen_below[i];
        end
    endgenerate

    assign multi_hot = |dup_line;
endmodule

// File: rtl/amb_policy.sv
module amb_policy #(
    parameter int LINES = 8
) (
    input  logic [LINES-1:0] raw_lines,
    input  logic [LINES-1:0] first_line,
    input  logic             multi_hot,
    input  amb_pkg::policy_e policy,
    output logic [LINES-1:0] out_lines,
    output logic             out_warn,
    output logic             out_block
);
    typedef struct packed {
        logic [LINES-1:0] lines;
        logic             warn;
        logic             block;
    } res_t;

    res_t res_d;

    always_comb begin
        res_d       = '0;
        res_d.lines = raw_lines;
        if (multi_hot) begin
            if (policy == amb_pkg::POL_WARN) begin
                res_d.lines = '0;
                res_d.warn  = 1'b1;
                res_d.block = 1'b1;
            end else begin
                res_d.lines = first_line;
            end
        end
    end

    assign out_lines = res_d.lines;
    assign out_warn  = res_d.warn;
    assign out_block = res_d.block;
endmodule

// File: rtl/amb_resolver.sv
module amb_resolver #(
    parameter int LINES = 8
) (
    input  logic [LINES-1:0] sense_lines,
    input  logic             policy_sel,
    output logic [LINES-1:0] clean_lines,
    output logic             warn_lamp,
    output logic             strobe_block
);
    import amb_pkg::*;

    logic [LINES-1:0] first_d;
    logic             multi_d;
    policy_e          policy_d;

    assign policy_d = policy_e'(policy_sel);

    amb_lowest_isolate #(.LINES(LINES)) u_iso (
        .raw_lines  (sense_lines),
        .first_line (first_d),
        .multi_hot  (multi_d)
    );

    amb_policy #(.LINES(LINES)) u_pol (
        .raw_lines  (sense_lines),
        .first_line (first_d),
        .multi_hot  (multi_d),
        .policy     (policy_d),
        .out_lines  (clean_lines),
        .out_warn   (warn_lamp),
        .out_block  (strobe_block)
    );

    // Output-side checks against the raw inputs
    always_comb begin
        assert_onehot_out_R9: assert ($onehot0(clean_lines))
            else $error("clean_lines not one-hot-or-zero");
        assert_subset_R9: assert ((clean_lines & ~sense_lines) == '0)
            else $error("clean_lines has a bit not excited");
        assert_warn_block_R9: assert (warn_lamp == strobe_block)
            else $error("warn and block disagree");
        assert_idle_R1: assert (sense_lines != '0 || (clean_lines == '0 && !warn_lamp))
            else $error("output with no excited line");
        assert_single_pass_R2: assert ($countones(sense_lines) != 1
                                       || (clean_lines == sense_lines && !warn_lamp))
            else $error("single line not passed unchanged");
        assert_warn_multi_R4: assert (!($countones(sense_lines) > 1 && !policy_sel)
                                      || (strobe_block && clean_lines == '0))
            else $error("warning policy did not block");
        assert_lowest_quiet_R6: assert (!policy_sel || !warn_lamp)
            else $error("lowest-code policy raised warning");
    end
endmodule

// File: tb/amb_resolver_tb.sv
module amb_resolver_tb_top;
    localparam int LINES = 8;

    logic             clk = 1'b0;
    logic [LINES-1:0] sense_lines = '0;
    logic             policy_sel  = 1'b0;
    logic [LINES-1:0] clean_lines;
    logic             warn_lamp;
    logic             strobe_block;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    amb_resolver #(.LINES(LINES)) dut_i (
        .sense_lines  (sense_lines),
        .policy_sel   (policy_sel),
        .clean_lines  (clean_lines),
        .warn_lamp    (warn_lamp),
        .strobe_block (strobe_block)
    );

    function automatic logic [LINES+1:0] model(input logic [LINES-1:0] s, input logic m);
        int cnt = $countones(s);
        logic [LINES-1:0] low = '0;
        bit found = 0;
        if (cnt <= 1) return {s, 2'b00};
        if (!m) return {{LINES{1'b0}}, 2'b11};
        for (int i = 0; i < LINES; i++) begin
            if (s[i] && !found) begin
                low[i] = 1'b1;
                found = 1;
            end
        end
        return {low, 2'b00};
    endfunction

    function automatic string tag_of(input logic [LINES-1:0] s, input logic m);
        int cnt = $countones(s);
        if (cnt == 0) return "R1";
        if (cnt == 1) return "R2";
        if (!m) begin
            if (cnt == 2 && ((s & (s >> 1)) != '0)) return "R3";
            if (cnt == 2) return "R5";
            return "R4";
        end
        if (cnt == 2) return "R6";
        return "R7";
    endfunction

    task automatic apply_check(input logic [LINES-1:0] s, input logic m, input string extra);
        logic [LINES+1:0] exp;
        @(negedge clk);
        sense_lines = s;
        policy_sel  = m;
        #1; // no clock edge between drive and sample: R8
        exp = model(s, m);
        total++;
        if ({clean_lines, warn_lamp, strobe_block} !== exp) begin
            bad++;
            $display("FAIL %s%s in=%b pol=%0b act lines=%b warn=%0b blk=%0b exp lines=%b warn=%0b blk=%0b",
                     tag_of(s, m), extra, s, m, clean_lines, warn_lamp, strobe_block,
                     exp[LINES+1:2], exp[1], exp[0]);
        end
    endtask

    function automatic logic [LINES-1:0] gen_pattern();
        int cls = $urandom % 5;
        int a   = $urandom % LINES;
        int b   = $urandom % LINES;
        logic [LINES-1:0] v = '0;
        case (cls)
            0: v = '0;
            1: v[a] = 1'b1;
            2: begin
                if (a == LINES - 1) a = LINES - 2;
                v[a] = 1'b1; v[a+1] = 1'b1;
            end
            3: begin
                v[a] = 1'b1; v[b] = 1'b1;
            end
            default: v = LINES'($urandom);
        endcase
        return v;
    endfunction

    initial begin
        void'($urandom(32'd1970));
        // R1 idle state
        apply_check('0, 1'b0, "");
        apply_check('0, 1'b1, "");
        // R2 single lines at both ends
        apply_check(8'b0000_0001, 1'b0, "");
        apply_check(8'b1000_0000, 1'b1, "");
        // R3 neighbouring pair, warning policy, top and bottom
        apply_check(8'b1100_0000, 1'b0, "");
        apply_check(8'b0000_0011, 1'b0, "");
        // R5 spread pair, warning policy
        apply_check(8'b1000_0001, 1'b0, "");
        // R4 all lines lit, warning policy
        apply_check(8'hFF, 1'b0, "");
        // R6 pairs, lowest-code policy
        apply_check(8'b1100_0000, 1'b1, "");
        apply_check(8'b0010_0100, 1'b1, "");
        // R7 dense patterns, lowest-code policy
        apply_check(8'hFF, 1'b1, "");
        apply_check(8'b1011_0000, 1'b1, "");
        // R8 flip policy alone with lines held
        apply_check(8'b0001_1000, 1'b0, " R8");
        apply_check(8'b0001_1000, 1'b1, " R8");
        apply_check(8'b0001_1000, 1'b0, " R8");
        // random classes, each under both policies (R9 via output shape)
        for (int k = 0; k < 400; k++) begin
            logic [LINES-1:0] p = gen_pattern();
            apply_check(p, 1'b0, " R9");
            apply_check(p, 1'b1, " R9");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired R8 act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule